// File: doc/BRIEF.md
# Two-Agent Write-Invalidate Coherent Cache Pair

Two private caches, each serving its own processor port, share one bus to a word-addressed memory. Every line is Invalid, Shared or Modified. A read miss fills a line as Shared. A write first wins the bus and broadcasts an invalidate for its address, then keeps the line as Modified. Each cache watches every transaction the other one places on the bus.

When a remote read miss hits a line that a cache holds in Modified form, that cache drives the data onto the bus in place of memory. In the same cycle the value is written back to memory and the owner drops to Shared. A round-robin arbiter gives the bus to one cache at a time, and every snoop resolves in the same cycle as the bus transaction. A processor pulses a request and holds no handshake. The cache answers with a one-cycle ready pulse carrying the read data, or, for a write, the written word.

Each cache is direct-mapped with one-word lines. The line count, address width and data width are parameters. A Modified victim is written back before its line is refilled.

Top module: `snoop_pair_top`

## Requirements
- R1: While rst_ni is low both ready outputs are 0. After reset all lines are Invalid and the memory reads as zero, so a first read of any address returns 0.
- R2: A read miss fills the line as Shared and returns the memory word. A later read of the same address returns the same word. Each accepted request yields exactly one ready pulse, one cycle wide.
- R3: A write takes the line to Modified by an invalidate on the bus. After that, the other cache's next read of that address misses and returns the newly written value.
- R4: A remote read miss to a line held Modified is answered by the owner, never by memory. The owner writes the value back to memory and keeps the line as Shared. At most one cache supplies data in any cycle.
- R5: Sequence A reads X, B reads X, A writes 1 to X, B reads X returns 1 to B. Afterwards A reads 1, and once both caches have evicted X, a fresh read of X returns 1 from memory.
- R6: A Modified line replaced by a different address (same index, different tag) is first written back, so another cache reading the old address gets the written value.
- R7: Writes to one address from both caches are serialised by the bus. Afterwards both caches read the same value, and it is one of the two written values.
- R8: At most one cache holds the bus in a cycle, and only a cache that requests it.
- R9: If a local write to a Modified line falls in the same cycle as a snooped remote read of that line, the snoop wins. The reader gets the value from before the write, and the write then completes through an invalidate, so the reader's next read returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 2 | One-cycle request pulse per processor port |
| cpu_we_i | input | 2 | 1 = write, 0 = read, per port |
| cpu_addr_i | input | 2*AW | Word address per port |
| cpu_wdata_i | input | 2*DW | Write data per port |
| cpu_ready_o | output | 2 | One-cycle completion pulse per port |
| cpu_rdata_o | output | 2*DW | Read data (or written word) valid with ready |

## Verification
A cache's local write hit on a Modified line and its snoop of the other cache's read miss to that same line can land in one cycle. This is provoked by first making cache A own X, then giving A a write to X and B a read of X at the same clock edge. B reaches the bus while A tries to finish its write locally. The bench expects B to receive the value from before the write and A's write to complete afterwards, and checks that B's next read returns the new value. Simultaneous writes from both ports to one address are judged by the two caches reading back an identical value.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam int NUM_PORTS = 2;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_MOD = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_RD  = 2'd0,
    BC_INV = 2'd1,
    BC_WB  = 2'd2
  } bus_cmd_e;
endpackage

// File: rtl/coh_arbiter.sv
module coh_arbiter import coh_pkg::*; (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] req_i,
  output logic [NUM_PORTS-1:0] gnt_o
);
  logic last_q;

  always_comb begin
    if (req_i == 2'b11) gnt_o = last_q ? 2'b01 : 2'b10;
    else                gnt_o = req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= 1'b1;
    else if (|gnt_o) last_q <= gnt_o[1];
  end

  a_r8_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  a_r8_grant_to_requester: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/coh_memory.sv
module coh_memory #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  assign rdata_o = mem_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/coh_cache.sv
module coh_cache import coh_pkg::*; #(
  parameter int AW    = 6,
  parameter int DW    = 8,
  parameter int LINES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic          bus_req_o,
  output bus_cmd_e      bus_cmd_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_gnt_i,
  input  logic          bus_valid_i,
  input  bus_cmd_e      bus_cmd_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          snoop_supply_o,
  output logic [DW-1:0] snoop_data_o
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;

  typedef enum logic {FS_IDLE, FS_BUSY} fsm_e;

  fsm_e          fsm_q;
  logic          rq_we_q;
  logic [AW-1:0] rq_addr_q;
  logic [DW-1:0] rq_wdata_q;
  logic          ready_q;
  logic [DW-1:0] rdata_q;

  line_st_e      st_q   [LINES];
  logic [TW-1:0] tag_q  [LINES];
  logic [DW-1:0] data_q [LINES];

  logic [IW-1:0] lidx, sidx;
  logic [TW-1:0] ltag, stag;
  logic busy, hit, hit_mod, dirty_victim;
  logic remote, snp_hit, snp_rd_mod, snp_inv, conflict;
  logic loc_rd_done, loc_wr_done, bus_done;

  assign lidx = rq_addr_q[IW-1:0];
  assign ltag = rq_addr_q[AW-1:IW];
  assign sidx = bus_addr_i[IW-1:0];
  assign stag = bus_addr_i[AW-1:IW];
  assign busy = (fsm_q == FS_BUSY);

  assign hit          = (st_q[lidx] != LS_INV) && (tag_q[lidx] == ltag);
  assign hit_mod      = hit && (st_q[lidx] == LS_MOD);
  assign dirty_victim = (st_q[lidx] == LS_MOD) && (tag_q[lidx] != ltag);

  // snoop side: only transactions of the other agent
  assign remote     = bus_valid_i && !bus_gnt_i;
  assign snp_hit    = remote && (st_q[sidx] != LS_INV) && (tag_q[sidx] == stag);
  assign snp_rd_mod = snp_hit && (bus_cmd_i == BC_RD) && (st_q[sidx] == LS_MOD);
  assign snp_inv    = snp_hit && (bus_cmd_i == BC_INV);
  assign conflict   = snp_hit && (sidx == lidx);

  assign snoop_supply_o = snp_rd_mod;
  assign snoop_data_o   = data_q[sidx];

  // local completion; a write yields to a snoop on the same line
  assign loc_rd_done = busy && !rq_we_q && hit;
  assign loc_wr_done = busy && rq_we_q && hit_mod && !conflict;

  assign bus_req_o   = busy && !(!rq_we_q && hit) && !(rq_we_q && hit_mod);
  assign bus_cmd_o   = dirty_victim ? BC_WB : (rq_we_q ? BC_INV : BC_RD);
  assign bus_addr_o  = dirty_victim ? {tag_q[lidx], lidx} : rq_addr_q;
  assign bus_wdata_o = dirty_victim ? data_q[lidx] : rq_wdata_q;
  assign bus_done    = bus_gnt_i && (bus_cmd_o != BC_WB);

  assign ready_o = ready_q;
  assign rdata_o = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q      <= FS_IDLE;
      rq_we_q    <= 1'b0;
      rq_addr_q  <= '0;
      rq_wdata_q <= '0;
      ready_q    <= 1'b0;
      rdata_q    <= '0;
    end else begin
      ready_q <= loc_rd_done || loc_wr_done || bus_done;
      if (loc_rd_done)                  rdata_q <= data_q[lidx];
      else if (bus_done && !rq_we_q)    rdata_q <= bus_rdata_i;
      else if (loc_wr_done || bus_done) rdata_q <= rq_wdata_q;
      case (fsm_q)
        FS_IDLE: if (req_i) begin
          fsm_q      <= FS_BUSY;
          rq_we_q    <= we_i;
          rq_addr_q  <= addr_i;
          rq_wdata_q <= wdata_i;
        end
        default: if (loc_rd_done || loc_wr_done || bus_done) fsm_q <= FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= LS_INV;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (snp_inv)    st_q[sidx] <= LS_INV;
      if (snp_rd_mod) st_q[sidx] <= LS_SHR;
      if (loc_wr_done) data_q[lidx] <= rq_wdata_q;
      if (bus_gnt_i) begin
        case (bus_cmd_o)
          BC_WB: st_q[lidx] <= LS_INV;
          BC_RD: begin
            st_q[lidx]   <= LS_SHR;
            tag_q[lidx]  <= ltag;
            data_q[lidx] <= bus_rdata_i;
          end
          default: begin
            st_q[lidx]   <= LS_MOD;
            tag_q[lidx]  <= ltag;
            data_q[lidx] <= rq_wdata_q;
          end
        endcase
      end
    end
  end

  a_r2_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |=> !ready_q);
  a_r3_invalidate_drops_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_inv |=> st_q[$past(sidx)] == LS_INV);
  a_r4_owner_downgrades: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_rd_mod |=> st_q[$past(sidx)] == LS_SHR);
  a_r9_supplied_word_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_rd_mod |=> data_q[$past(sidx)] == $past(snoop_data_o));
  a_r2_no_bus_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_rd_done |-> !bus_req_o);
endmodule

// File: rtl/snoop_pair_top.sv
module snoop_pair_top import coh_pkg::*; #(
  parameter int AW    = 6,
  parameter int DW    = 8,
  parameter int LINES = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_PORTS-1:0]          cpu_req_i,
  input  logic [NUM_PORTS-1:0]          cpu_we_i,
  input  logic [NUM_PORTS-1:0][AW-1:0]  cpu_addr_i,
  input  logic [NUM_PORTS-1:0][DW-1:0]  cpu_wdata_i,
  output logic [NUM_PORTS-1:0]          cpu_ready_o,
  output logic [NUM_PORTS-1:0][DW-1:0]  cpu_rdata_o
);
  logic [NUM_PORTS-1:0]         bus_req, bus_gnt, supply;
  bus_cmd_e                     req_cmd   [NUM_PORTS];
  logic [NUM_PORTS-1:0][AW-1:0] req_addr;
  logic [NUM_PORTS-1:0][DW-1:0] req_wdata, supply_data;

  logic          bus_valid, sel, supply_any;
  bus_cmd_e      bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata, mem_rdata, mem_wdata, sup_word;
  logic          mem_we;

  coh_arbiter i_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (bus_req),
    .gnt_o  (bus_gnt)
  );

  assign bus_valid  = |bus_gnt;
  assign sel        = bus_gnt[1];
  assign bus_cmd    = req_cmd[sel];
  assign bus_addr   = req_addr[sel];
  assign bus_wdata  = req_wdata[sel];
  assign supply_any = |supply;
  assign sup_word   = supply[1] ? supply_data[1] : supply_data[0];
  // owner data cancels the memory answer
  assign bus_rdata  = supply_any ? sup_word : mem_rdata;
  assign mem_we     = (bus_valid && bus_cmd == BC_WB) || supply_any;
  assign mem_wdata  = supply_any ? sup_word : bus_wdata;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_cache
    coh_cache #(.AW(AW), .DW(DW), .LINES(LINES)) i_cache (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .req_i          (cpu_req_i[g]),
      .we_i           (cpu_we_i[g]),
      .addr_i         (cpu_addr_i[g]),
      .wdata_i        (cpu_wdata_i[g]),
      .ready_o        (cpu_ready_o[g]),
      .rdata_o        (cpu_rdata_o[g]),
      .bus_req_o      (bus_req[g]),
      .bus_cmd_o      (req_cmd[g]),
      .bus_addr_o     (req_addr[g]),
      .bus_wdata_o    (req_wdata[g]),
      .bus_gnt_i      (bus_gnt[g]),
      .bus_valid_i    (bus_valid),
      .bus_cmd_i      (bus_cmd),
      .bus_addr_i     (bus_addr),
      .bus_rdata_i    (bus_rdata),
      .snoop_supply_o (supply[g]),
      .snoop_data_o   (supply_data[g])
    );
  end

  coh_memory #(.AW(AW), .DW(DW)) i_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .addr_i  (bus_addr),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );

  a_r4_single_supplier: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(supply) <= 1);
  a_r4_supply_only_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_any |-> (bus_valid && bus_cmd == BC_RD));
  a_r4_supplier_not_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply & bus_gnt) == '0);
endmodule

// File: tb/test_snoop_pair_top.sv
module test_snoop_pair_top;
  localparam int AW = 6;
  localparam int DW = 8;

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [1:0]            cpu_req = '0;
  logic [1:0]            cpu_we = '0;
  logic [1:0][AW-1:0]    cpu_addr = '0;
  logic [1:0][DW-1:0]    cpu_wdata = '0;
  logic [1:0]            cpu_ready;
  logic [1:0][DW-1:0]    cpu_rdata;

  int checks = 0;
  int errors = 0;
  int pending [2];
  logic [DW-1:0] last_rd [2];

  logic [DW-1:0] exp_q [2][$];
  bit            dc_q  [2][$];
  string         tag_q [2][$];

  always #5 clk = ~clk;

  snoop_pair_top #(.AW(AW), .DW(DW), .LINES(4)) i_snoop_pair_top (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cpu_req_i   (cpu_req),
    .cpu_we_i    (cpu_we),
    .cpu_addr_i  (cpu_addr),
    .cpu_wdata_i (cpu_wdata),
    .cpu_ready_o (cpu_ready),
    .cpu_rdata_o (cpu_rdata)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input int p, input bit we, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [DW-1:0] exp,
                       input bit dc, input string tag);
    while (pending[p] != 0) @(negedge clk);
    exp_q[p].push_back(exp);
    dc_q[p].push_back(dc);
    tag_q[p].push_back(tag);
    pending[p]++;
    cpu_we[p]    = we;
    cpu_addr[p]  = a;
    cpu_wdata[p] = d;
    cpu_req[p]   = 1'b1;
    @(negedge clk);
    cpu_req[p]   = 1'b0;
  endtask

  task automatic settle();
    while (pending[0] != 0 || pending[1] != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (rst_ni && cpu_ready[p]) begin
        if (exp_q[p].size() == 0) begin
          checks++; errors++;
          $display("FAIL R2: unexpected ready on port %0d actual %0h expected none", p, cpu_rdata[p]);
        end else begin
          logic [DW-1:0] e;
          bit dc;
          string t;
          e = exp_q[p].pop_front();
          dc = dc_q[p].pop_front();
          t = tag_q[p].pop_front();
          if (!dc) check(t, cpu_rdata[p], e);
          last_rd[p] = cpu_rdata[p];
          pending[p]--;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [AW-1:0] X = 6'h05;  // index 1
  localparam logic [AW-1:0] Y = 6'h09;  // index 1, other tag
  localparam logic [AW-1:0] Z = 6'h02;  // index 2

  initial begin
    pending[0] = 0; pending[1] = 0;
    repeat (3) @(negedge clk);
    check("R1 reset ready A", {7'b0, cpu_ready[0]}, 8'h00);
    check("R1 reset ready B", {7'b0, cpu_ready[1]}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);

    // R5 trace, with R1 and R2 on the first reads
    issue(0, 0, X, 0, 8'h00, 0, "R1 A first read X");
    settle();
    issue(1, 0, X, 0, 8'h00, 0, "R2 B read miss X");
    settle();
    issue(0, 1, X, 8'h01, 8'h01, 0, "R3 A write X");
    settle();
    issue(1, 0, X, 0, 8'h01, 0, "R5 B reads X after A write");
    settle();
    issue(0, 0, X, 0, 8'h01, 0, "R5 A still holds X=1");
    settle();
    issue(1, 0, X, 0, 8'h01, 0, "R2 B read hit X");
    settle();
    // evict X in both, then memory must hold 1
    issue(0, 0, Y, 0, 8'h00, 0, "R2 A read Y");
    issue(1, 0, Y, 0, 8'h00, 0, "R2 B read Y");
    settle();
    issue(0, 0, X, 0, 8'h01, 0, "R5 memory holds X=1 (R4 writeback)");
    settle();

    // R6 dirty victim written back
    issue(1, 1, Y, 8'h22, 8'h22, 0, "R3 B write Y");
    settle();
    issue(1, 0, X, 0, 8'h01, 0, "R6 B reads X replacing dirty Y");
    settle();
    issue(0, 0, Y, 0, 8'h22, 0, "R6 A reads Y written back");
    settle();

    // R9 snoop read versus local write on a Modified line
    issue(0, 1, X, 8'h03, 8'h03, 0, "R3 A write X=3");
    settle();
    fork
      issue(0, 1, X, 8'h04, 8'h04, 0, "R9 A write X=4");
      issue(1, 0, X, 0, 8'h03, 0, "R9 B gets pre-write value");
    join
    settle();
    issue(1, 0, X, 0, 8'h04, 0, "R9 B next read sees new value");
    settle();
    issue(0, 0, X, 0, 8'h04, 0, "R4 A keeps X after supply");
    settle();

    // R7 simultaneous writes to one address
    for (int k = 0; k < 2; k++) begin
      logic [DW-1:0] va, vb;
      va = 8'h11 + 8'(k * 16);
      vb = 8'h12 + 8'(k * 16);
      fork
        issue(0, 1, Z, va, va, 0, "R7 A write Z");
        issue(1, 1, Z, vb, vb, 0, "R7 B write Z");
      join
      settle();
      issue(0, 0, Z, 0, 0, 1, "R7 A read Z");
      settle();
      issue(1, 0, Z, 0, 0, 1, "R7 B read Z");
      settle();
      check("R7 both caches agree", last_rd[1], last_rd[0]);
      check("R7 value is one written",
            {7'b0, (last_rd[0] == va) || (last_rd[0] == vb)}, 8'h01);
    end

    // R3 invalidate on a Shared copy held by the reader
    issue(1, 0, Z, 0, 0, 1, "R2 B read Z");
    settle();
    issue(0, 1, Z, 8'h5a, 8'h5a, 0, "R3 A write Z shared");
    settle();
    issue(1, 0, Z, 0, 8'h5a, 0, "R3 B misses after invalidate");
    settle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule